// File: doc/BRIEF.md
# Disk DMA transfer sequencer

This block carries out one complete disk transfer after the controller's register file asks for it. When `start` arrives it captures the function code, the 16-bit bus address, the two address-extension bits, the word count and the disk address. From these it forms an 18-bit memory byte address and a linear byte offset into a byte-wide disk store. It then streams 16-bit words between a memory port and a disk byte port. On the disk side each word occupies two bytes, with the low byte at the lower offset.

Three data functions exist. A read moves words from disk to memory. A write moves words from memory to disk. A write-check compares memory against disk without writing either side. A write to a drive that the register block reports as write-locked is rejected at once and moves nothing.

When a data function finishes, the block presents the updated bus address, extension bits and word count. The register block loads these into its registers during the single-cycle `done` pulse.

Top module: `dxfer_seq`

## Requirements
- R1: The number of words moved is 65536 minus `reg_wc`, so a word count of 0 moves 65536 words.
- R2: Memory accesses start at the byte address `{reg_ext, reg_ba}` (extension bits above bit 15). Each access is 2 higher than the previous one, modulo 2^18.
- R3: The first disk byte used is 512 × (cylinder × 12 + sector), where the cylinder is `reg_da[12:4]` and the sector is `reg_da[3:0]`. Successive bytes follow consecutively.
- R4: Word k of memory corresponds to disk bytes 2k (bits 7:0) and 2k+1 (bits 15:8), both measured from the first disk byte.
- R5: With `done` of a data function, `upd_valid` is 1 and `upd_wc` is 0. `{upd_ext, upd_ba}` equals the 18-bit start address plus twice the word total, wrapped to 18 bits.
- R6: A read (`fn` = 2) writes every word into memory and writes nothing to disk.
- R7: A write (`fn` = 1) writes every word onto disk and writes nothing to memory.
- R8: A write while `wlock` is 1 makes no memory or disk access. It raises `done` with `err_wlo` = 1 and `upd_valid` = 0 in the first cycle after `start`. `err_wlo` is 0 after any other accepted start.
- R9: A write-check (`fn` = 3) writes to neither port. It leaves `err_wce` at 1 after `done` if any word differs, and at 0 otherwise. Each accepted start clears `err_wce`.
- R10: `busy` is 1 from the cycle after an accepted `start` through the `done` cycle. `done` is a one-cycle pulse, 2N+3 cycles after the start cycle for a data function of N words.
- R11: Function code 0 makes no access and raises `done` in the first cycle after `start`, with `upd_valid` = 0.
- R12: A `start` that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one transfer (accepted when idle) |
| fn | input | 2 | 0 none, 1 write, 2 read, 3 write-check |
| wlock | input | 1 | Selected drive is write-locked |
| reg_ba | input | 16 | Bus address register value |
| reg_ext | input | 2 | Address-extension bits 17:16 |
| reg_wc | input | 16 | Two's-complement negative word count |
| reg_da | input | 13 | Cylinder and sector fields of the disk address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| upd_valid | output | 1 | Update values below are to be loaded |
| upd_ba | output | 16 | New bus address |
| upd_ext | output | 2 | New extension bits |
| upd_wc | output | 16 | New word count |
| err_wlo | output | 1 | Last start was rejected by write lock |
| err_wce | output | 1 | Last write-check found a mismatch |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 18 | Memory byte address |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 16 | Memory read word, one cycle after request |
| dsk_req | output | 1 | Disk store access this cycle |
| dsk_we | output | 1 | Disk access is a write |
| dsk_addr | output | 22 | Disk byte offset |
| dsk_wdata | output | 8 | Disk write byte |
| dsk_rdata | input | 8 | Disk read byte, one cycle after request |

## Verification
The assertions assume that memory and the disk store return read data exactly one cycle after a read request, with no stall. They also assume that `start` is not held high across the cycle in which the transfer returns to idle. The bench models both stores as zero-wait arrays that answer on the next clock edge. It pulses `start` for a single cycle and keeps bus addresses even, so the address-step and write-lock properties cover only legal traffic. The one deliberate start during a busy transfer is issued well inside the data phase.

// File: rtl/dxfer_pkg.sv
package dxfer_pkg;

  localparam int WORD_W = 16;
  localparam int EXT_W  = 2;
  localparam int PA_W   = WORD_W + EXT_W;
  localparam int SEC_W  = 4;
  localparam int CYL_W  = 9;
  localparam int DA_W   = CYL_W + SEC_W;
  localparam int BIDX_W = WORD_W + 1;

  typedef enum logic [1:0] {
    FN_NONE  = 2'd0,
    FN_WRITE = 2'd1,
    FN_READ  = 2'd2,
    FN_CHECK = 2'd3
  } xfer_fn_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_FINISH
  } seq_state_e;

  // Word total from the negative count: 2^16 - wc (0 -> 65536).
  function automatic logic [WORD_W:0] words_of(input logic [WORD_W-1:0] wc);
    logic [WORD_W:0] full;
    full = '0;
    full[WORD_W] = 1'b1;
    return full - {1'b0, wc};
  endfunction

  function automatic logic [PA_W-1:0] phys_of(input logic [EXT_W-1:0] ext,
                                              input logic [WORD_W-1:0] ba);
    return {ext, ba};
  endfunction

  // Final address: start plus two bytes per word, wrapping at 2^18.
  function automatic logic [PA_W-1:0] advance(input logic [PA_W-1:0] phys,
                                              input logic [WORD_W-1:0] wc);
    return phys + {words_of(wc), 1'b0};
  endfunction

endpackage

// File: rtl/dxfer_geom.sv
module dxfer_geom
  import dxfer_pkg::*;
#(
  parameter int SECT_PER_TRK = 12,
  parameter int SECT_BYTES   = 512,
  parameter int DISK_AW      = 22
) (
  input  logic [DA_W-1:0]    da,
  output logic [DISK_AW-1:0] base
);

  localparam int SECT_SH = $clog2(SECT_BYTES);

  logic [CYL_W-1:0]   cyl;
  logic [SEC_W-1:0]   sec;
  logic [DISK_AW-1:0] lin;

  assign cyl = da[DA_W-1:SEC_W];
  assign sec = da[SEC_W-1:0];
  assign lin = DISK_AW'(cyl) * DISK_AW'(SECT_PER_TRK) + DISK_AW'(sec);

  generate
    if ((1 << SECT_SH) == SECT_BYTES) begin : g_shift
      assign base = lin << SECT_SH;
    end else begin : g_mul
      assign base = lin * DISK_AW'(SECT_BYTES);
    end
  endgenerate

endmodule

// File: rtl/dxfer_ctrl.sv
module dxfer_ctrl
  import dxfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              moves_data,
  input  logic [BIDX_W-1:0] last_b,
  output seq_state_e        state,
  output logic              accept,
  output logic              issue,
  output logic              issue_last,
  output logic [BIDX_W-1:0] b_idx
);

  logic drain_q;

  assign accept     = start && (state == ST_IDLE);
  assign issue      = (state == ST_RUN);
  assign issue_last = issue && (b_idx == last_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      b_idx   <= '0;
      drain_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            b_idx <= '0;
            state <= moves_data ? ST_RUN : ST_FINISH;
          end
        end
        ST_RUN: begin
          if (issue_last) begin
            state   <= ST_DRAIN;
            drain_q <= 1'b0;
          end else begin
            b_idx <= b_idx + BIDX_W'(1);
          end
        end
        ST_DRAIN: begin
          if (drain_q) state <= ST_FINISH;
          else         drain_q <= 1'b1;
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dxfer_dpath.sv
module dxfer_dpath
  import dxfer_pkg::*;
#(
  parameter int DISK_AW = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  xfer_fn_e           fn_q,
  input  logic               issue,
  input  logic [BIDX_W-1:0]  b_idx,
  input  logic [PA_W-1:0]    phys_q,
  input  logic [DISK_AW-1:0] dbase_q,
  input  logic [WORD_W-1:0]  mem_rdata,
  input  logic [7:0]         dsk_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [PA_W-1:0]    mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  output logic               dsk_req,
  output logic               dsk_we,
  output logic [DISK_AW-1:0] dsk_addr,
  output logic [7:0]         dsk_wdata,
  output logic               cmp_fail,
  output logic               wce_q
);

  // Stage 1: read data returns. Stage 2: write to the opposite port.
  logic              p1_v, p2_v;
  logic [BIDX_W-1:0] p1_b, p2_b;
  logic [WORD_W-1:0] word_q;
  logic [7:0]        lo_q;

  logic              want_mem_rd, want_dsk_rd, put_mem, put_dsk;
  logic [BIDX_W-1:0] mem_b;

  assign want_mem_rd = issue && !b_idx[0] && (fn_q == FN_WRITE || fn_q == FN_CHECK);
  assign want_dsk_rd = issue && (fn_q == FN_READ || fn_q == FN_CHECK);
  assign put_mem     = p2_v && p2_b[0] && (fn_q == FN_READ);
  assign put_dsk     = p2_v && (fn_q == FN_WRITE);

  assign mem_b     = put_mem ? p2_b : b_idx;
  assign mem_req   = want_mem_rd || put_mem;
  assign mem_we    = put_mem;
  assign mem_addr  = phys_q + (PA_W'(mem_b) & ~PA_W'(1));
  assign mem_wdata = word_q;

  assign dsk_req   = want_dsk_rd || put_dsk;
  assign dsk_we    = put_dsk;
  assign dsk_addr  = dbase_q + DISK_AW'(put_dsk ? p2_b : b_idx);
  assign dsk_wdata = p2_b[0] ? word_q[WORD_W-1:8] : word_q[7:0];

  assign cmp_fail = p1_v && p1_b[0] && (fn_q == FN_CHECK) &&
                    ({dsk_rdata, lo_q} != word_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v   <= 1'b0;
      p2_v   <= 1'b0;
      p1_b   <= '0;
      p2_b   <= '0;
      word_q <= '0;
      lo_q   <= '0;
      wce_q  <= 1'b0;
    end else begin
      p1_v <= issue;
      p1_b <= b_idx;
      p2_v <= p1_v;
      p2_b <= p1_b;
      if (p1_v) begin
        unique case (fn_q)
          FN_READ: begin
            if (!p1_b[0]) lo_q   <= dsk_rdata;
            else          word_q <= {dsk_rdata, lo_q};
          end
          FN_WRITE: begin
            if (!p1_b[0]) word_q <= mem_rdata;
          end
          FN_CHECK: begin
            if (!p1_b[0]) begin
              word_q <= mem_rdata;
              lo_q   <= dsk_rdata;
            end
          end
          default: ;
        endcase
      end
      if (accept)        wce_q <= 1'b0;
      else if (cmp_fail) wce_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dxfer_seq.sv
module dxfer_seq
  import dxfer_pkg::*;
#(
  parameter int SECT_PER_TRK = 12,
  parameter int SECT_BYTES   = 512,
  parameter int DISK_AW      = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         fn,
  input  logic               wlock,
  input  logic [15:0]        reg_ba,
  input  logic [1:0]         reg_ext,
  input  logic [15:0]        reg_wc,
  input  logic [12:0]        reg_da,
  output logic               busy,
  output logic               done,
  output logic               upd_valid,
  output logic [15:0]        upd_ba,
  output logic [1:0]         upd_ext,
  output logic [15:0]        upd_wc,
  output logic               err_wlo,
  output logic               err_wce,
  output logic               mem_req,
  output logic               mem_we,
  output logic [17:0]        mem_addr,
  output logic [15:0]        mem_wdata,
  input  logic [15:0]        mem_rdata,
  output logic               dsk_req,
  output logic               dsk_we,
  output logic [DISK_AW-1:0] dsk_addr,
  output logic [7:0]         dsk_wdata,
  input  logic [7:0]         dsk_rdata
);

  xfer_fn_e           fn_in, fn_q;
  seq_state_e         state;
  logic               accept, issue, issue_last, moves_data, cmp_fail;
  logic               wlo_q, moved_q;
  logic [BIDX_W-1:0]  b_idx, last_b;
  logic [PA_W-1:0]    phys_q, adv;
  logic [WORD_W-1:0]  wc_q;
  logic [DISK_AW-1:0] dbase_w, dbase_q;

  assign fn_in      = xfer_fn_e'(fn);
  assign moves_data = (fn_in != FN_NONE) && !(fn_in == FN_WRITE && wlock);
  assign last_b     = {~wc_q, 1'b1};

  dxfer_geom #(
    .SECT_PER_TRK(SECT_PER_TRK),
    .SECT_BYTES  (SECT_BYTES),
    .DISK_AW     (DISK_AW)
  ) u_geom (
    .da  (reg_da),
    .base(dbase_w)
  );

  dxfer_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .moves_data(moves_data),
    .last_b    (last_b),
    .state     (state),
    .accept    (accept),
    .issue     (issue),
    .issue_last(issue_last),
    .b_idx     (b_idx)
  );

  dxfer_dpath #(.DISK_AW(DISK_AW)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .fn_q     (fn_q),
    .issue    (issue),
    .b_idx    (b_idx),
    .phys_q   (phys_q),
    .dbase_q  (dbase_q),
    .mem_rdata(mem_rdata),
    .dsk_rdata(dsk_rdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .dsk_req  (dsk_req),
    .dsk_we   (dsk_we),
    .dsk_addr (dsk_addr),
    .dsk_wdata(dsk_wdata),
    .cmp_fail (cmp_fail),
    .wce_q    (err_wce)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q    <= FN_NONE;
      phys_q  <= '0;
      wc_q    <= '0;
      dbase_q <= '0;
      wlo_q   <= 1'b0;
      moved_q <= 1'b0;
    end else if (accept) begin
      fn_q    <= fn_in;
      phys_q  <= phys_of(reg_ext, reg_ba);
      wc_q    <= reg_wc;
      dbase_q <= dbase_w;
      wlo_q   <= (fn_in == FN_WRITE) && wlock;
      moved_q <= moves_data;
    end
  end

  assign adv       = advance(phys_q, wc_q);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FINISH);
  assign upd_valid = done && moved_q;
  assign upd_ba    = adv[WORD_W-1:0];
  assign upd_ext   = adv[PA_W-1:WORD_W];
  assign upd_wc    = '0;
  assign err_wlo   = wlo_q;

endmodule

// File: rtl/dxfer_chk.sv
module dxfer_chk
  import dxfer_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  fn,
  input logic        wlock,
  input logic        accept,
  input xfer_fn_e    fn_q,
  input logic        busy,
  input logic        done,
  input logic        upd_valid,
  input logic [15:0] upd_wc,
  input logic        err_wlo,
  input logic        mem_req,
  input logic        mem_we,
  input logic [17:0] mem_addr,
  input logic        dsk_req,
  input logic        dsk_we
);

  logic [PA_W-1:0] prev_addr;
  logic            have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else if (accept) begin
      have_prev <= 1'b0;
    end else if (mem_req) begin
      prev_addr <= mem_addr;
      have_prev <= 1'b1;
    end
  end

  // R2: memory addresses advance by one word per access
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && have_prev) |-> (mem_addr == prev_addr + PA_W'(2)));

  a_r5_wc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_wc == '0));

  a_r6_no_disk_write_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fn_q == FN_READ) |-> !(dsk_req && dsk_we));

  a_r7_no_mem_write_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fn_q == FN_WRITE) |-> !(mem_req && mem_we));

  a_r8_wlock_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fn == 2'd1 && wlock) |=> (done && err_wlo && !upd_valid && !mem_req && !dsk_req));

  a_r9_check_no_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fn_q == FN_CHECK) |-> !((mem_req && mem_we) || (dsk_req && dsk_we)));

  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

bind dxfer_seq dxfer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .fn       (fn),
  .wlock    (wlock),
  .accept   (accept),
  .fn_q     (fn_q),
  .busy     (busy),
  .done     (done),
  .upd_valid(upd_valid),
  .upd_wc   (upd_wc),
  .err_wlo  (err_wlo),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .dsk_req  (dsk_req),
  .dsk_we   (dsk_we)
);

// File: tb/tb_dxfer_seq.sv
`timescale 1ns/1ps
module tb_dxfer_seq;

  localparam int DISK_AW = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  fn = 2'd0;
  logic        wlock = 1'b0;
  logic [15:0] reg_ba = '0;
  logic [1:0]  reg_ext = '0;
  logic [15:0] reg_wc = '0;
  logic [12:0] reg_da = '0;
  logic        busy, done, upd_valid, err_wlo, err_wce;
  logic [15:0] upd_ba, upd_wc;
  logic [1:0]  upd_ext;
  logic        mem_req, mem_we, dsk_req, dsk_we;
  logic [17:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [DISK_AW-1:0] dsk_addr;
  logic [7:0]  dsk_wdata;
  logic [7:0]  dsk_rdata = '0;

  dxfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fn(fn), .wlock(wlock),
    .reg_ba(reg_ba), .reg_ext(reg_ext), .reg_wc(reg_wc), .reg_da(reg_da),
    .busy(busy), .done(done), .upd_valid(upd_valid), .upd_ba(upd_ba),
    .upd_ext(upd_ext), .upd_wc(upd_wc), .err_wlo(err_wlo), .err_wce(err_wce),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dsk_req(dsk_req), .dsk_we(dsk_we), .dsk_addr(dsk_addr),
    .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata)
  );

  // Store models: contents default to address patterns until written.
  logic [15:0] mem_m [int];
  logic [7:0]  dsk_m [int];
  int mem_wr_n = 0, mem_rd_n = 0, dsk_wr_n = 0, dsk_rd_n = 0;

  function automatic logic [15:0] mpat(int a);
    return 16'(a ^ 32'h3C00 ^ (a >> 4));
  endfunction
  function automatic logic [7:0] dpat(int a);
    return 8'(a * 13 + 7 + (a >> 8));
  endfunction
  function automatic logic [15:0] mem_get(int a);
    return mem_m.exists(a) ? mem_m[a] : mpat(a);
  endfunction
  function automatic logic [7:0] dsk_get(int a);
    return dsk_m.exists(a) ? dsk_m[a] : dpat(a);
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin mem_m[int'(mem_addr)] = mem_wdata; mem_wr_n++; end
      else begin mem_rdata <= mem_get(int'(mem_addr)); mem_rd_n++; end
    end
    if (dsk_req) begin
      if (dsk_we) begin dsk_m[int'(dsk_addr)] = dsk_wdata; dsk_wr_n++; end
      else begin dsk_rdata <= dsk_get(int'(dsk_addr)); dsk_rd_n++; end
    end
  end

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Results of the last transfer
  int lat, mw, mr, dw, dr, gaps;
  logic c_uv, c_wlo, c_wce, c_after_idle;
  logic [15:0] c_ba, c_wc;
  logic [1:0]  c_ext;

  task automatic wait_done(input int mw0, input int mr0, input int dw0, input int dr0);
    lat = 1; gaps = 0;
    while (!done && lat < 140000) begin
      if (!busy) gaps++;
      @(negedge clk); lat++;
    end
    c_uv = upd_valid; c_ba = upd_ba; c_ext = upd_ext; c_wc = upd_wc;
    c_wlo = err_wlo; c_wce = err_wce;
    mw = mem_wr_n - mw0; mr = mem_rd_n - mr0;
    dw = dsk_wr_n - dw0; dr = dsk_rd_n - dr0;
    @(negedge clk);
    c_after_idle = !busy && !done;
  endtask

  task automatic xfer(input logic [1:0] f, input logic [15:0] ba, input logic [1:0] ext,
                      input logic [15:0] wc, input logic [12:0] da, input logic wl);
    int mw0, mr0, dw0, dr0;
    mw0 = mem_wr_n; mr0 = mem_rd_n; dw0 = dsk_wr_n; dr0 = dsk_rd_n;
    @(negedge clk);
    fn = f; reg_ba = ba; reg_ext = ext; reg_wc = wc; reg_da = da; wlock = wl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(mw0, mr0, dw0, dr0);
  endtask

  function automatic int offs(int cyl, int sec);
    return 512 * (cyl * 12 + sec);
  endfunction

  task automatic t_reset();
    chk("R10", "busy after reset", busy, 0);
    chk("R10", "done after reset", done, 0);
    chk("R10", "no access after reset", mem_req | dsk_req, 0);
  endtask

  task automatic t_read();
    int o, p;
    o = offs(3, 5); p = 32'h11000;
    xfer(2'd2, 16'h1000, 2'd1, 16'hFFFC, {9'd3, 4'd5}, 1'b0);
    chk("R10", "read latency", lat, 11);
    chk("R10", "busy held", gaps, 0);
    chk("R10", "idle after done", c_after_idle, 1);
    chk("R6", "read mem writes", mw, 4);
    chk("R6", "read disk writes", dw, 0);
    for (int i = 0; i < 4; i++)
      chk("R4", "read word", mem_get(p + 2*i), {dpat(o + 2*i + 1), dpat(o + 2*i)});
    chk("R5", "read upd_valid", c_uv, 1);
    chk("R5", "read upd_ba", c_ba, 16'h1008);
    chk("R5", "read upd_ext", c_ext, 2'd1);
    chk("R5", "read upd_wc", c_wc, 0);
    chk("R8", "err_wlo clear", c_wlo, 0);
  endtask

  task automatic t_write_geom();
    int o, p;
    o = offs(511, 11); p = 32'h1FFFC;
    xfer(2'd1, 16'hFFFC, 2'd1, 16'hFFFD, {9'd511, 4'd11}, 1'b0);
    chk("R10", "write latency", lat, 9);
    chk("R7", "write mem writes", mw, 0);
    chk("R7", "write disk writes", dw, 6);
    for (int i = 0; i < 3; i++) begin
      chk("R3", "write low byte", dsk_get(o + 2*i), mem_get(p + 2*i) & 16'hFF);
      chk("R4", "write high byte", dsk_get(o + 2*i + 1), mem_get(p + 2*i) >> 8);
    end
    chk("R5", "carry into ext ba", c_ba, 16'h0002);
    chk("R5", "carry into ext", c_ext, 2'd2);
  endtask

  task automatic t_wrap();
    xfer(2'd2, 16'hFFFE, 2'd3, 16'hFFFE, 13'd0, 1'b0);
    chk("R2", "wrap first word", mem_get(32'h3FFFE), {dpat(1), dpat(0)});
    chk("R2", "wrap second word", mem_get(0), {dpat(3), dpat(2)});
    chk("R5", "wrap upd_ba", c_ba, 16'h0002);
    chk("R5", "wrap upd_ext", c_ext, 2'd0);
  endtask

  task automatic t_check();
    xfer(2'd1, 16'h2000, 2'd0, 16'hFFF8, {9'd10, 4'd2}, 1'b0);
    xfer(2'd3, 16'h2000, 2'd0, 16'hFFF8, {9'd10, 4'd2}, 1'b0);
    chk("R9", "match err_wce", c_wce, 0);
    chk("R9", "check writes", mw + dw, 0);
    chk("R9", "check reads", dr, 16);
    chk("R10", "check latency", lat, 19);
    chk("R5", "check upd_ba", c_ba, 16'h2010);
    xfer(2'd3, 16'h2002, 2'd0, 16'hFFF8, {9'd10, 4'd2}, 1'b0);
    chk("R9", "mismatch err_wce", c_wce, 1);
    chk("R9", "mismatch writes", mw + dw, 0);
    xfer(2'd3, 16'h2000, 2'd0, 16'hFFFF, {9'd10, 4'd2}, 1'b0);
    chk("R9", "err_wce cleared by start", c_wce, 0);
  endtask

  task automatic t_wlock();
    xfer(2'd1, 16'h4000, 2'd0, 16'hFFF0, 13'd0, 1'b1);
    chk("R8", "wlock latency", lat, 1);
    chk("R8", "wlock err", c_wlo, 1);
    chk("R8", "wlock upd_valid", c_uv, 0);
    chk("R8", "wlock accesses", mw + mr + dw + dr, 0);
    xfer(2'd2, 16'h4000, 2'd0, 16'hFFFF, 13'd0, 1'b1);
    chk("R8", "wlock ignored for read", c_wlo, 0);
    chk("R8", "read under wlock moves", mw, 1);
  endtask

  task automatic t_none();
    xfer(2'd0, 16'h5000, 2'd0, 16'hFFF0, 13'd0, 1'b0);
    chk("R11", "none latency", lat, 1);
    chk("R11", "none upd_valid", c_uv, 0);
    chk("R11", "none accesses", mw + mr + dw + dr, 0);
  endtask

  task automatic t_busy_start();
    int mw0, mr0, dw0, dr0;
    mw0 = mem_wr_n; mr0 = mem_rd_n; dw0 = dsk_wr_n; dr0 = dsk_rd_n;
    @(negedge clk);
    fn = 2'd2; reg_ba = 16'h3000; reg_ext = 2'd0; reg_wc = 16'hFFF8; reg_da = 13'd0;
    wlock = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    fn = 2'd1; reg_ba = 16'h7000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 3;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
    chk("R12", "latency with extra start", lat, 19);
    chk("R12", "extra start no disk writes", dsk_wr_n - dw0, 0);
    chk("R12", "extra start mem writes", mem_wr_n - mw0, 8);
    chk("R12", "update from first start", upd_ba, 16'h3010);
    @(negedge clk);
    chk("R12", "idle after", busy, 0);
  endtask

  task automatic t_full();
    xfer(2'd2, 16'h0000, 2'd0, 16'h0000, 13'd0, 1'b0);
    chk("R1", "full latency", lat, 131075);
    chk("R1", "full mem writes", mw, 65536);
    chk("R1", "full last word", mem_get(32'h1FFFE), {dpat(131071), dpat(131070)});
    chk("R5", "full upd_ba", c_ba, 16'h0000);
    chk("R5", "full upd_ext", c_ext, 2'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write_geom();
    t_wrap();
    t_check();
    t_wlock();
    t_none();
    t_busy_start();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule